// File: doc/BRIEF.md
# AXI Write Width Downsizer (128 to 64 bits)

This block sits between a 128-bit AXI write master and a 64-bit AXI write slave. It accepts one write address, the write data beats that belong to it, and hands back the slave's write response. The address phase is rewritten for the narrow side. Full-width bursts (16 bytes per beat) become bursts of twice as many 8-byte beats. Narrower transfers keep their length and size.

Each wide data beat leaves as one or two narrow beats. A full-width beat is split into its lower and upper halves, and each half carries its own strobe byte. A transfer narrower than 16 bytes needs only one narrow beat. That beat is taken from the half of the wide word picked by bit 3 of the running beat address. The block also checks each wide strobe against the byte window that the beat address and size allow, and it pulses an error output when a strobe falls outside that window. Only incrementing bursts and single transfers are handled, with one write in flight at a time.

Top module: `axi_wr_downsizer`

## Requirements
- R1: A write address of size 4 (16 bytes) with length L leaves with size 3 (8 bytes) and length 2L+1. The address and ID are unchanged. Master lengths are limited to 0..127 for this size.
- R2: A write address of size 0 to 3 leaves with its length and size unchanged.
- R3: In a size-4 transfer, each wide beat yields two narrow beats in order. The first carries data bits 63:0 with strobe bits 7:0. The second carries data bits 127:64 with strobe bits 15:8. Both hold steady while the slave stalls.
- R4: The slave's write response code and ID are returned unchanged to the master. The response holds until the master accepts it.
- R5: In a transfer of size 0 to 3, each wide beat yields exactly one narrow beat. That beat takes the lower half (data 63:0, strobe 7:0) when bit 3 of the beat address is 0. It takes the upper half (data 127:64, strobe 15:8) when that bit is 1. The first beat address is the AW address. Each later beat address is the previous one aligned down to the size, plus 2^size.
- R6: A wide beat may have a strobe bit set outside the window that starts at the beat address's byte offset within 16 bytes and ends at the end of its size-aligned container. Such a beat raises err_o for exactly the cycle after it is accepted, and its data is still forwarded.
- R7: m_wlast is high only on the final narrow beat made from the master's beat that carried s_wlast.
- R8: s_wready stays low while any narrow beat made from the previous wide beat has not yet been accepted by the slave.
- R9: s_awready is high only when no write is in progress. After an address is accepted, it stays low until the response has been delivered to the master.
- R10: After reset, s_awready is 1 and m_awvalid, m_wvalid, s_bvalid and err_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_awid | input | ID_W | Master write ID |
| s_awaddr | input | ADDR_W | Master write address |
| s_awlen | input | 8 | Master burst length minus one |
| s_awsize | input | 3 | Master bytes-per-beat code |
| s_awvalid | input | 1 | Master address valid |
| s_awready | output | 1 | Address accepted |
| s_wdata | input | WIDE_W | Wide write data |
| s_wstrb | input | WIDE_W/8 | Wide byte strobes |
| s_wlast | input | 1 | Last wide beat |
| s_wvalid | input | 1 | Wide data valid |
| s_wready | output | 1 | Wide beat accepted |
| s_bid | output | ID_W | Response ID to master |
| s_bresp | output | 2 | Response code to master |
| s_bvalid | output | 1 | Response valid to master |
| s_bready | input | 1 | Master accepts response |
| m_awid | output | ID_W | Slave write ID |
| m_awaddr | output | ADDR_W | Slave write address |
| m_awlen | output | 8 | Slave burst length minus one |
| m_awsize | output | 3 | Slave bytes-per-beat code |
| m_awvalid | output | 1 | Slave address valid |
| m_awready | input | 1 | Slave accepts address |
| m_wdata | output | NARROW_W | Narrow write data |
| m_wstrb | output | NARROW_W/8 | Narrow byte strobes |
| m_wlast | output | 1 | Last narrow beat |
| m_wvalid | output | 1 | Narrow data valid |
| m_wready | input | 1 | Slave accepts data |
| m_bid | input | ID_W | Slave response ID |
| m_bresp | input | 2 | Slave response code |
| m_bvalid | input | 1 | Slave response valid |
| m_bready | output | 1 | Response accepted from slave |
| err_o | output | 1 | Strobe outside the address window |

## Verification
The bench sends a single byte write to lane 7 and a single byte write to lane 15. A design that always forwarded the lower half would send zero strobes for the lane-15 write. It also sends a byte write whose address points at lane 15 while its strobe marks lane 7. A correct design raises err_o and forwards the upper half with an empty strobe. A split full-width beat with only strobe bit 7 set must come out as 0x80 followed by 0x00; swapped halves would show up at once. Full-width bursts run against a slave that is ready only every other cycle, which exposes a misplaced m_wlast or a master beat accepted too early. Narrow bursts, one aligned and one starting unaligned, check the alternating half selection and the address stepping.

// File: rtl/axi_ds_pkg.sv
package axi_ds_pkg;
  typedef enum logic [2:0] {
    CT_IDLE,
    CT_AW,
    CT_DATA,
    CT_BWAIT,
    CT_BOUT
  } ctl_state_t;

  typedef enum logic [1:0] {
    WS_EMPTY,
    WS_LO,
    WS_HI,
    WS_ONE
  } wsp_state_t;
endpackage

// File: rtl/ds_aw_conv.sv
module ds_aw_conv #(
  parameter int LEN_W  = 8,
  parameter int WIDE_B = 16
) (
  input  logic [2:0]       size_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [2:0]       size_o,
  output logic [LEN_W-1:0] len_o,
  output logic             split_o
);
  localparam int WIDE_SZ   = $clog2(WIDE_B);
  localparam int NARROW_SZ = WIDE_SZ - 1;

  always_comb begin
    split_o = (size_i == 3'(WIDE_SZ));
    if (split_o) begin
      size_o = 3'(NARROW_SZ);
      len_o  = {len_i[LEN_W-2:0], 1'b1};
    end else begin
      size_o = size_i;
      len_o  = len_i;
    end
  end
endmodule

// File: rtl/ds_lane_check.sv
module ds_lane_check #(
  parameter int WIDE_B = 16,
  localparam int OFF_W = $clog2(WIDE_B)
) (
  input  logic [OFF_W-1:0]  off_i,
  input  logic [2:0]        size_i,
  input  logic [WIDE_B-1:0] strb_i,
  output logic              bad_o
);
  logic [OFF_W-1:0]  sz_mask;
  logic [OFF_W-1:0]  top_lane;
  logic [WIDE_B-1:0] allow;

  always_comb begin
    sz_mask  = OFF_W'((32'd1 << size_i) - 32'd1);
    top_lane = off_i | sz_mask;
  end

  for (genvar g = 0; g < WIDE_B; g++) begin : g_lane
    assign allow[g] = (OFF_W'(g) >= off_i) && (OFF_W'(g) <= top_lane);
  end

  assign bad_o = |(strb_i & ~allow);
endmodule

// File: rtl/ds_w_split.sv
module ds_w_split
  import axi_ds_pkg::*;
#(
  parameter int WIDE_W   = 128,
  parameter int NARROW_W = 64,
  localparam int WIDE_B  = WIDE_W / 8,
  localparam int NB      = NARROW_W / 8,
  localparam int OFF_W   = $clog2(WIDE_B),
  localparam int HALF_B  = $clog2(NB)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic [OFF_W-1:0]    start_off_i,
  input  logic [2:0]          size_i,
  input  logic                split_i,
  input  logic                active_i,
  input  logic [WIDE_W-1:0]   s_wdata,
  input  logic [WIDE_B-1:0]   s_wstrb,
  input  logic                s_wlast,
  input  logic                s_wvalid,
  output logic                s_wready,
  output logic [NARROW_W-1:0] m_wdata,
  output logic [NB-1:0]       m_wstrb,
  output logic                m_wlast,
  output logic                m_wvalid,
  input  logic                m_wready,
  output logic                err_o,
  output logic                done_o
);
  wsp_state_t          wst;
  logic [OFF_W-1:0]    beat_off, nxt_off, sz_mask;
  logic [2:0]          size_r;
  logic                split_r, last_r, lane_bad, take;
  logic [NARROW_W-1:0] hi_data;
  logic [NB-1:0]       hi_strb;

  ds_lane_check #(.WIDE_B(WIDE_B)) u_lane (
    .off_i (beat_off),
    .size_i(size_r),
    .strb_i(s_wstrb),
    .bad_o (lane_bad)
  );

  always_comb begin
    sz_mask = OFF_W'((32'd1 << size_r) - 32'd1);
    nxt_off = (beat_off & ~sz_mask) + sz_mask + 1'b1;
  end

  assign s_wready = active_i && (wst == WS_EMPTY);
  assign take     = s_wvalid && s_wready;
  assign done_o   = m_wvalid && m_wready && m_wlast;

  always_ff @(posedge clk) begin
    if (rst) begin
      wst      <= WS_EMPTY;
      m_wvalid <= 1'b0;
      m_wlast  <= 1'b0;
      err_o    <= 1'b0;
      beat_off <= '0;
      size_r   <= '0;
      split_r  <= 1'b0;
      last_r   <= 1'b0;
    end else begin
      err_o <= 1'b0;
      if (start_i) begin
        beat_off <= start_off_i;
        size_r   <= size_i;
        split_r  <= split_i;
      end
      case (wst)
        WS_EMPTY: if (take) begin
          err_o    <= lane_bad;
          last_r   <= s_wlast;
          m_wvalid <= 1'b1;
          beat_off <= nxt_off;
          if (split_r) begin
            m_wlast <= 1'b0;
            wst     <= WS_LO;
          end else begin
            m_wlast <= s_wlast;
            wst     <= WS_ONE;
          end
        end
        WS_LO: if (m_wready) begin
          m_wlast <= last_r;
          wst     <= WS_HI;
        end
        default: if (m_wready) begin
          m_wvalid <= 1'b0;
          m_wlast  <= 1'b0;
          wst      <= WS_EMPTY;
        end
      endcase
    end
  end

  // Data path registers carry no reset
  always_ff @(posedge clk) begin
    if (wst == WS_EMPTY && take) begin
      hi_data <= s_wdata[WIDE_W-1:NARROW_W];
      hi_strb <= s_wstrb[WIDE_B-1:NB];
      if (!split_r && beat_off[HALF_B]) begin
        m_wdata <= s_wdata[WIDE_W-1:NARROW_W];
        m_wstrb <= s_wstrb[WIDE_B-1:NB];
      end else begin
        m_wdata <= s_wdata[NARROW_W-1:0];
        m_wstrb <= s_wstrb[NB-1:0];
      end
    end else if (wst == WS_LO && m_wready) begin
      m_wdata <= hi_data;
      m_wstrb <= hi_strb;
    end
  end

  AST_NARROW_HOLD: assert property (@(posedge clk) disable iff (rst)
    m_wvalid && !m_wready |=> m_wvalid && $stable(m_wdata) && $stable(m_wstrb) && $stable(m_wlast)); // R3
  AST_NO_EARLY_WREADY: assert property (@(posedge clk) disable iff (rst)
    s_wvalid && s_wready |=> m_wvalid && !s_wready); // R8
  AST_ERR_AFTER_BEAT: assert property (@(posedge clk) disable iff (rst)
    err_o |-> $past(s_wvalid && s_wready)); // R6
  AST_END_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    m_wvalid && m_wready && m_wlast |=> !m_wvalid); // R7
endmodule

// File: rtl/axi_wr_downsizer.sv
module axi_wr_downsizer
  import axi_ds_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int ID_W     = 4,
  parameter int WIDE_W   = 128,
  parameter int NARROW_W = 64,
  localparam int LEN_W   = 8,
  localparam int WIDE_B  = WIDE_W / 8,
  localparam int NB      = NARROW_W / 8,
  localparam int OFF_W   = $clog2(WIDE_B)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ID_W-1:0]     s_awid,
  input  logic [ADDR_W-1:0]   s_awaddr,
  input  logic [LEN_W-1:0]    s_awlen,
  input  logic [2:0]          s_awsize,
  input  logic                s_awvalid,
  output logic                s_awready,
  input  logic [WIDE_W-1:0]   s_wdata,
  input  logic [WIDE_B-1:0]   s_wstrb,
  input  logic                s_wlast,
  input  logic                s_wvalid,
  output logic                s_wready,
  output logic [ID_W-1:0]     s_bid,
  output logic [1:0]          s_bresp,
  output logic                s_bvalid,
  input  logic                s_bready,
  output logic [ID_W-1:0]     m_awid,
  output logic [ADDR_W-1:0]   m_awaddr,
  output logic [LEN_W-1:0]    m_awlen,
  output logic [2:0]          m_awsize,
  output logic                m_awvalid,
  input  logic                m_awready,
  output logic [NARROW_W-1:0] m_wdata,
  output logic [NB-1:0]       m_wstrb,
  output logic                m_wlast,
  output logic                m_wvalid,
  input  logic                m_wready,
  input  logic [ID_W-1:0]     m_bid,
  input  logic [1:0]          m_bresp,
  input  logic                m_bvalid,
  output logic                m_bready,
  output logic                err_o
);
  ctl_state_t       st;
  logic [2:0]       cv_size;
  logic [LEN_W-1:0] cv_len;
  logic             cv_split, aw_take, w_done;

  ds_aw_conv #(.LEN_W(LEN_W), .WIDE_B(WIDE_B)) u_conv (
    .size_i (s_awsize),
    .len_i  (s_awlen),
    .size_o (cv_size),
    .len_o  (cv_len),
    .split_o(cv_split)
  );

  assign s_awready = (st == CT_IDLE);
  assign m_bready  = (st == CT_BWAIT);
  assign aw_take   = s_awvalid && s_awready;

  ds_w_split #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_split (
    .clk        (clk),
    .rst        (rst),
    .start_i    (aw_take),
    .start_off_i(s_awaddr[OFF_W-1:0]),
    .size_i     (s_awsize),
    .split_i    (cv_split),
    .active_i   (st == CT_DATA),
    .s_wdata    (s_wdata),
    .s_wstrb    (s_wstrb),
    .s_wlast    (s_wlast),
    .s_wvalid   (s_wvalid),
    .s_wready   (s_wready),
    .m_wdata    (m_wdata),
    .m_wstrb    (m_wstrb),
    .m_wlast    (m_wlast),
    .m_wvalid   (m_wvalid),
    .m_wready   (m_wready),
    .err_o      (err_o),
    .done_o     (w_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= CT_IDLE;
      m_awvalid <= 1'b0;
      s_bvalid  <= 1'b0;
      m_awid    <= '0;
      m_awaddr  <= '0;
      m_awlen   <= '0;
      m_awsize  <= '0;
      s_bid     <= '0;
      s_bresp   <= '0;
    end else begin
      case (st)
        CT_IDLE: if (aw_take) begin
          m_awid    <= s_awid;
          m_awaddr  <= s_awaddr;
          m_awlen   <= cv_len;
          m_awsize  <= cv_size;
          m_awvalid <= 1'b1;
          st        <= CT_AW;
        end
        CT_AW: if (m_awready) begin
          m_awvalid <= 1'b0;
          st        <= CT_DATA;
        end
        CT_DATA: if (w_done) st <= CT_BWAIT;
        CT_BWAIT: if (m_bvalid) begin
          s_bid    <= m_bid;
          s_bresp  <= m_bresp;
          s_bvalid <= 1'b1;
          st       <= CT_BOUT;
        end
        default: if (s_bready) begin
          s_bvalid <= 1'b0;
          st       <= CT_IDLE;
        end
      endcase
    end
  end

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
    s_awvalid && s_awready |=> !s_awready); // R9
  AST_AW_HOLD: assert property (@(posedge clk) disable iff (rst)
    m_awvalid && !m_awready |=> m_awvalid && $stable(m_awaddr) && $stable(m_awlen) && $stable(m_awsize)); // R1
  AST_B_HOLD: assert property (@(posedge clk) disable iff (rst)
    s_bvalid && !s_bready |=> s_bvalid && $stable(s_bresp) && $stable(s_bid)); // R4
  AST_NO_AW_DURING_DATA: assert property (@(posedge clk) disable iff (rst)
    m_wvalid |-> !s_awready); // R9
endmodule

// File: tb/axi_wr_downsizer_bench.sv
module axi_wr_downsizer_bench;
  logic clk = 1'b0, rst = 1'b1;
  always #2 clk = ~clk;

  logic [3:0] s_awid; logic [31:0] s_awaddr; logic [7:0] s_awlen; logic [2:0] s_awsize;
  logic s_awvalid, s_awready;
  logic [127:0] s_wdata; logic [15:0] s_wstrb; logic s_wlast, s_wvalid, s_wready;
  logic [3:0] s_bid; logic [1:0] s_bresp; logic s_bvalid, s_bready;
  logic [3:0] m_awid; logic [31:0] m_awaddr; logic [7:0] m_awlen; logic [2:0] m_awsize;
  logic m_awvalid, m_awready;
  logic [63:0] m_wdata; logic [7:0] m_wstrb; logic m_wlast, m_wvalid, m_wready;
  logic [3:0] m_bid; logic [1:0] m_bresp; logic m_bvalid, m_bready, err_o;

  axi_wr_downsizer u_axi_wr_downsizer (.*);

  int nchk = 0, nerr = 0;
  int rdy_mode = 0;
  logic [1:0] resp_cfg = 2'b00;
  logic [63:0] cap_d [16]; logic [7:0] cap_s [16]; logic cap_l [16];
  int ncap = 0, naw = 0, nb = 0, errs = 0, viol = 0;
  logic [31:0] aw_addr; logic [7:0] aw_len; logic [2:0] aw_size; logic [3:0] aw_id;
  logic [3:0] got_bid; logic [1:0] got_bresp;
  logic pend_b = 1'b0, b_go = 1'b0;

  // Slave model and port monitor, all at the falling edge
  always @(negedge clk) begin
    if (rst) begin
      m_wready = 1'b0; m_awready = 1'b1; m_bvalid = 1'b0; m_bid = '0; m_bresp = '0;
    end else begin
      m_awready = 1'b1;
      if (rdy_mode == 0) m_wready = 1'b1; else m_wready = ~m_wready;
      if (m_awvalid && m_awready) begin
        aw_addr = m_awaddr; aw_len = m_awlen; aw_size = m_awsize; aw_id = m_awid; naw++;
      end
      if (m_wvalid && m_wready && ncap < 16) begin
        cap_d[ncap] = m_wdata; cap_s[ncap] = m_wstrb; cap_l[ncap] = m_wlast; ncap++;
        if (m_wlast) pend_b = 1'b1;
      end
      if (b_go) begin m_bvalid = 1'b0; b_go = 1'b0; end
      else if (m_bvalid && m_bready) b_go = 1'b1;
      else if (pend_b && !m_bvalid) begin
        m_bvalid = 1'b1; m_bid = aw_id; m_bresp = resp_cfg; pend_b = 1'b0;
      end
      if (s_bvalid && s_bready) begin got_bid = s_bid; got_bresp = s_bresp; nb++; end
      if (err_o) errs++;
      if (s_wready && m_wvalid) viol++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_caps();
    ncap = 0; naw = 0; nb = 0; errs = 0; viol = 0;
  endtask

  task automatic send_aw(input logic [31:0] a, input logic [7:0] l,
                         input logic [2:0] sz, input logic [3:0] id);
    @(negedge clk);
    s_awaddr = a; s_awlen = l; s_awsize = sz; s_awid = id; s_awvalid = 1'b1;
    while (!s_awready) @(negedge clk);
    @(negedge clk);
    s_awvalid = 1'b0;
    chk(s_awready == 1'b0, "R9", "awready after accept", 128'(s_awready), 128'd0);
  endtask

  task automatic send_w(input logic [127:0] d, input logic [15:0] st, input logic last);
    s_wdata = d; s_wstrb = st; s_wlast = last; s_wvalid = 1'b1;
    while (!s_wready) @(negedge clk);
    @(negedge clk);
    s_wvalid = 1'b0;
  endtask

  task automatic wait_b();
    int t;
    t = 0;
    while (nb == 0 && t < 300) begin
      if (t == 1) chk(s_awready == 1'b0, "R9", "awready before response", 128'(s_awready), 128'd0);
      @(negedge clk); t++;
    end
    repeat (2) @(negedge clk);
  endtask

  localparam logic [127:0] DEMO = 128'hABCDEF01_10FEDCBA_12345678_87654321;

  task automatic t_reset();
    chk(s_awready === 1'b1 && m_awvalid === 1'b0 && m_wvalid === 1'b0 &&
        s_bvalid === 1'b0 && err_o === 1'b0, "R10", "reset outputs",
        {s_awready, m_awvalid, m_wvalid, s_bvalid, err_o}, 128'b10000);
  endtask

  task automatic t_full_single();
    clear_caps(); resp_cfg = 2'b00;
    send_aw(32'h4000_9090, 8'd0, 3'd4, 4'h5);
    send_w(DEMO, 16'h0080, 1'b1);
    wait_b();
    chk(aw_size == 3'd3 && aw_len == 8'd1, "R1", "full size/len", {aw_size, aw_len}, {3'd3, 8'd1});
    chk(aw_addr == 32'h4000_9090 && aw_id == 4'h5, "R1", "addr/id", {aw_id, aw_addr}, {4'h5, 32'h4000_9090});
    chk(ncap == 2, "R3", "beat count", ncap, 2);
    chk(cap_d[0] == DEMO[63:0] && cap_s[0] == 8'h80, "R3", "first half", {cap_s[0], cap_d[0]}, {8'h80, DEMO[63:0]});
    chk(cap_d[1] == DEMO[127:64] && cap_s[1] == 8'h00, "R3", "second half", {cap_s[1], cap_d[1]}, {8'h00, DEMO[127:64]});
    chk(cap_l[0] == 1'b0 && cap_l[1] == 1'b1, "R7", "wlast placement", {cap_l[0], cap_l[1]}, 2'b01);
    chk(nb == 1 && got_bid == 4'h5 && got_bresp == 2'b00, "R4", "okay response", {got_bid, got_bresp}, {4'h5, 2'b00});
    chk(errs == 0, "R6", "no error on full beat", errs, 0);
  endtask

  task automatic t_byte(input logic [31:0] a, input logic [15:0] st, input bit hi,
                        input logic [7:0] exp_s, input int exp_err);
    clear_caps(); resp_cfg = 2'b00;
    send_aw(a, 8'd0, 3'd0, 4'h2);
    send_w(DEMO, st, 1'b1);
    wait_b();
    chk(aw_size == 3'd0 && aw_len == 8'd0, "R2", "byte size/len", {aw_size, aw_len}, 11'd0);
    chk(ncap == 1 && cap_l[0] == 1'b1, "R5", "one beat with last", ncap, 1);
    chk(cap_d[0] == (hi ? DEMO[127:64] : DEMO[63:0]) && cap_s[0] == exp_s, "R5", "half select",
        {cap_s[0], cap_d[0]}, {exp_s, (hi ? DEMO[127:64] : DEMO[63:0])});
    chk(errs == exp_err, "R6", "error pulses", errs, exp_err);
  endtask

  task automatic t_full_burst();
    logic [127:0] d;
    clear_caps(); rdy_mode = 1; resp_cfg = 2'b10;
    send_aw(32'h0000_1000, 8'd2, 3'd4, 4'hA);
    for (int i = 0; i < 3; i++) begin
      d = {32'(i), 32'hC0DE_0000 + 32'(i), 32'(i + 16), 32'hBEEF_0000 + 32'(i)};
      send_w(d, 16'hF00F + 16'(i), i == 2);
    end
    wait_b();
    rdy_mode = 0;
    chk(aw_len == 8'd5 && aw_size == 3'd3, "R1", "burst len", {aw_size, aw_len}, {3'd3, 8'd5});
    chk(ncap == 6, "R3", "burst beat count", ncap, 6);
    for (int i = 0; i < 3; i++) begin
      d = {32'(i), 32'hC0DE_0000 + 32'(i), 32'(i + 16), 32'hBEEF_0000 + 32'(i)};
      chk(cap_d[2*i] == d[63:0] && cap_d[2*i+1] == d[127:64], "R3", "burst data order",
          {cap_d[2*i+1], cap_d[2*i]}, d);
      chk(cap_s[2*i] == 8'h0F + 8'(i) && cap_s[2*i+1] == 8'hF0, "R3", "burst strobes",
          {cap_s[2*i+1], cap_s[2*i]}, {8'hF0, 8'h0F + 8'(i)});
      chk(cap_l[2*i] == 1'b0 && cap_l[2*i+1] == (i == 2), "R7", "burst wlast",
          {cap_l[2*i], cap_l[2*i+1]}, {1'b0, 1'(i == 2)});
    end
    chk(viol == 0, "R8", "wready while narrow beat pending", viol, 0);
    chk(got_bresp == 2'b10 && got_bid == 4'hA, "R4", "error response", {got_bid, got_bresp}, {4'hA, 2'b10});
  endtask

  task automatic t_narrow_burst();
    clear_caps(); resp_cfg = 2'b00;
    send_aw(32'h0000_2008, 8'd3, 3'd3, 4'h3);
    for (int i = 0; i < 4; i++)
      send_w({64'hAAAA_0000 + 64'(i), 64'h5555_0000 + 64'(i)},
             (i % 2 == 0) ? 16'hFF00 : 16'h00FF, i == 3);
    wait_b();
    chk(aw_len == 8'd3 && aw_size == 3'd3, "R2", "dword len/size", {aw_size, aw_len}, {3'd3, 8'd3});
    chk(ncap == 4, "R5", "dword beat count", ncap, 4);
    for (int i = 0; i < 4; i++) begin
      chk(cap_d[i] == ((i % 2 == 0) ? 64'hAAAA_0000 + 64'(i) : 64'h5555_0000 + 64'(i)) && cap_s[i] == 8'hFF,
          "R5", "alternating half", cap_d[i], (i % 2 == 0) ? 64'hAAAA_0000 + 64'(i) : 64'h5555_0000 + 64'(i));
    end
    chk(errs == 0, "R6", "aligned dwords clean", errs, 0);
  endtask

  task automatic t_unaligned();
    clear_caps(); resp_cfg = 2'b00;
    send_aw(32'h0000_3003, 8'd2, 3'd2, 4'h7);
    send_w(DEMO, 16'h0008, 1'b0);
    send_w(DEMO, 16'h00F0, 1'b0);
    send_w(DEMO, 16'h0F00, 1'b1);
    wait_b();
    chk(ncap == 3, "R5", "unaligned beat count", ncap, 3);
    chk(cap_s[0] == 8'h08 && cap_s[1] == 8'hF0 && cap_s[2] == 8'h0F, "R5", "unaligned strobes",
        {cap_s[0], cap_s[1], cap_s[2]}, 24'h08F00F);
    chk(cap_d[1] == DEMO[63:0] && cap_d[2] == DEMO[127:64], "R5", "step to upper half",
        {cap_d[1], cap_d[2]}, {DEMO[63:0], DEMO[127:64]});
    chk(errs == 0, "R6", "unaligned clean", errs, 0);
  endtask

  initial begin
    s_awid = '0; s_awaddr = '0; s_awlen = '0; s_awsize = '0; s_awvalid = 1'b0;
    s_wdata = '0; s_wstrb = '0; s_wlast = 1'b0; s_wvalid = 1'b0; s_bready = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_full_single();
    t_byte(32'h4000_9097, 16'h0080, 1'b0, 8'h80, 0);
    t_byte(32'h4000_909F, 16'h8000, 1'b1, 8'h80, 0);
    t_byte(32'h4000_909F, 16'h0080, 1'b1, 8'h00, 1);
    t_full_burst();
    t_narrow_burst();
    t_unaligned();
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog R9 actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule